// File: doc/BRIEF.md
# Page Write Buffer and Programming Controller

This block sits behind the serial front end of a byte-addressed non-volatile store. The front end hands it an already decoded 11-bit start address and then a stream of data bytes. The bytes are gathered in a 16-entry page buffer. The buffer is indexed by the low four address bits, and that index advances, and wraps, inside the page. The upper seven address bits select the page and do not change during a transaction.

Nothing reaches the 2048 x 8 storage array until the transaction ends with STOP. STOP starts a self-timed programming cycle whose length is a parameter in system clocks. A busy flag is high for exactly that many cycles. On the last cycle every buffer slot that was loaded is written into the array at once.

A write-protect input guards the upper half of the array. Its level is captured when the cycle starts. A protected page still runs a full busy cycle, but its array contents stay as they were. A combinational read port gives the front end the stored byte at any address.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0 and every array location reads 0x00.
- R2: A start address followed by one data byte and STOP stores that byte at that address once the busy cycle ends.
- R3: Each accepted data byte goes to address {page, index}. The index is the low 4 bits and increments modulo 16, so a write starting at 0x0FE puts its third byte at 0x0F0. The page bits (10:4) do not change.
- R4: If more than 16 data bytes arrive before STOP, the later bytes overwrite the earlier ones in the same slots. Only the last byte per slot is stored.
- R5: The array does not change before the busy cycle ends. At the end, only the slots loaded in this transaction are updated. All other bytes of the page keep their old values.
- R6: STOP after at least one data byte raises `busy_o` on the next clock. `busy_o` then stays high for exactly PROG_CYCLES clocks (20 by default).
- R7: If `wp_i` is 1 at STOP and address bit 10 of the page is 1 (0x400 to 0x7FF), the busy cycle still runs but the array is unchanged. If `wp_i` is 0, or the page is in the lower half, the write takes effect.
- R8: STOP with no data byte since the start address starts no cycle: `busy_o` stays 0 and the array is unchanged.
- R9: While `busy_o` is 1, the inputs `addr_load_i`, `byte_valid_i` and `stop_i` are ignored. They change neither the array nor the busy length, and they start no further cycle.
- R10: `rd_data_o` shows the array byte at `rd_addr_i` in the same cycle, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load_i | input | 1 | Strobe: start address of a new write transaction |
| addr_i | input | 11 | Start address (page in bits 10:4, slot in 3:0) |
| byte_valid_i | input | 1 | Strobe: one data byte accepted by the front end |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Strobe: STOP seen on the bus |
| wp_i | input | 1 | Write protect for the upper half, 1 = protected |
| rd_addr_i | input | 11 | Read address |
| rd_data_o | output | 8 | Stored byte at `rd_addr_i` |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The assertions assume that each strobe lasts one clock, that at most one of `addr_load_i`, `byte_valid_i` and `stop_i` is high in a cycle, and that data bytes come only after a start address. The stimulus drives each strobe for a single cycle from tasks, with idle cycles between them, so these rules always hold. Traffic sent during busy is deliberate. It exercises the guarantee that such traffic is ignored, and the per-clock reference model expects the same outcome.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    typedef struct packed {
        logic start;
        logic done;
    } prog_evt_t;

    function automatic logic page_locked(input logic upper_half, input logic guard);
        return upper_half & guard;
    endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 7,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_i,
    input  logic [PAGE_W+IDX_W-1:0]       load_addr_i,
    input  logic                          wr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  logic                          busy_i,
    output logic [PAGE_W-1:0]             page_o,
    output logic [(1<<IDX_W)-1:0]         mask_o,
    output logic [(1<<IDX_W)*DATA_W-1:0]  bytes_o
);
    localparam int SLOTS = 1 << IDX_W;

    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SLOTS-1:0]  mask_q;
    logic [DATA_W-1:0] slot_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
        end else if (load_i) begin
            page_q <= load_addr_i[PAGE_W+IDX_W-1:IDX_W];
            idx_q  <= load_addr_i[IDX_W-1:0];
            mask_q <= '0;
        end else if (wr_i) begin
            slot_q[idx_q] <= wr_data_i;
            mask_q[idx_q] <= 1'b1;
            idx_q         <= idx_q + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_flat
            assign bytes_o[g*DATA_W +: DATA_W] = slot_q[g];
        end
    endgenerate

    assign page_o = page_q;
    assign mask_o = mask_q;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_i && !load_i |=> idx_q == IDX_W'($past(idx_q) + 1'b1)); // R3
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        wr_i && !load_i |=> $stable(page_q)); // R3
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(mask_q)); // R9
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(PROG_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_q && cnt_q != '0 |=> busy_q); // R6
    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q); // R9
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we_i,
    input  logic [ADDR_W-IDX_W-1:0]       page_i,
    input  logic [(1<<IDX_W)-1:0]         mask_i,
    input  logic [(1<<IDX_W)*DATA_W-1:0]  bytes_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else if (we_i) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (mask_i[s]) mem_q[{page_i, IDX_W'(s)}] <= bytes_i[s*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl
    import pgw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int IDX_W       = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);
    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam int SLOTS  = 1 << IDX_W;

    phase_e                    phase_q;
    prog_evt_t                 evt;
    logic                      wp_lock_q;
    logic                      addr_take, byte_take, busy;
    logic [PAGE_W-1:0]         page;
    logic [SLOTS-1:0]          mask;
    logic [SLOTS*DATA_W-1:0]   bytes;
    logic                      store_we;

    assign addr_take = addr_load_i && (phase_q != PH_PROG);
    assign byte_take = byte_valid_i && (phase_q == PH_FILL) && !addr_load_i;
    assign evt.start = stop_i && (phase_q == PH_FILL) && !addr_load_i && !byte_valid_i && (|mask);
    assign store_we  = evt.done && !page_locked(page[PAGE_W-1], wp_lock_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            wp_lock_q <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (addr_take) phase_q <= PH_FILL;
                PH_FILL: begin
                    if (evt.start) begin
                        phase_q   <= PH_PROG;
                        wp_lock_q <= wp_i;
                    end else if (stop_i && !addr_load_i) begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_PROG: if (evt.done) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    pgw_page_buf #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst(rst),
        .load_i(addr_take), .load_addr_i(addr_i),
        .wr_i(byte_take), .wr_data_i(byte_i),
        .busy_i(busy),
        .page_o(page), .mask_o(mask), .bytes_o(bytes)
    );

    pgw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst),
        .start_i(evt.start), .busy_o(busy), .done_o(evt.done)
    );

    pgw_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .we_i(store_we), .page_i(page), .mask_i(mask), .bytes_i(bytes),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    assign busy_o = busy;

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i)); // R6
    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_i && !busy_o && mask == '0 |=> !busy_o); // R8
    AST_COMMIT_LAST: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !busy_o); // R5
    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(wp_lock_q)); // R7
    AST_PHASE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> phase_q == PH_PROG); // R9
endmodule

// File: tb/page_prog_ctrl_bench.sv
module page_prog_ctrl_bench;
    localparam int P = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        stop_i = 1'b0;
    logic        wp_i = 1'b0;
    logic [10:0] rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        busy_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    page_prog_ctrl #(.PROG_CYCLES(P)) u_page_prog_ctrl (
        .clk(clk), .rst(rst),
        .addr_load_i(addr_load_i), .addr_i(addr_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .stop_i(stop_i), .wp_i(wp_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    // behavioural reference model, advanced once per clock
    logic [7:0]  m_mem [2048];
    logic [7:0]  m_pend [int];
    bit          m_busy, m_open, m_prot;
    int          m_cnt, m_off;
    logic [10:0] m_base;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[a]) m_mem[a] = 8'h00;
            m_pend.delete();
            m_busy = 0; m_open = 0; m_prot = 0; m_cnt = 0; m_off = 0; m_base = '0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                if (!m_prot) foreach (m_pend[a]) m_mem[a] = m_pend[a];
                m_busy = 0;
            end
        end else if (addr_load_i) begin
            m_base = addr_i; m_off = 0; m_open = 1; m_pend.delete();
        end else if (byte_valid_i && m_open) begin
            m_pend[{m_base[10:4], 4'(m_base[3:0] + m_off)}] = byte_i;
            m_off++;
        end else if (stop_i && m_open) begin
            if (m_pend.num() > 0) begin
                m_busy = 1; m_cnt = P; m_prot = wp_i && m_base[10];
            end
            m_open = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model (R6, R10)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            #2;
            chk("R6 busy vs model", busy_o, m_busy);
            chk("R10 rd_data vs model", rd_data_o, m_mem[rd_addr_i]);
        end
    end

    task automatic send_addr(input logic [10:0] a);
        @(negedge clk); addr_load_i = 1; addr_i = a;
        @(negedge clk); addr_load_i = 0;
    endtask
    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); byte_valid_i = 1; byte_i = d;
        @(negedge clk); byte_valid_i = 0;
    endtask
    task automatic send_stop();
        @(negedge clk); stop_i = 1;
        @(negedge clk); stop_i = 0;
    endtask
    task automatic peek(input logic [10:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); rd_addr_i = a; #1;
        chk(tag, rd_data_o, exp);
    endtask
    task automatic wait_busy(output int n);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 busy after reset", busy_o, 0);
        peek(11'h000, 8'h00, "R1 mem 0x000");
        peek(11'h7FF, 8'h00, "R1 mem 0x7FF");

        // R2 single byte, R5 no change before commit, R6 length
        send_addr(11'h123); send_byte(8'hA5); send_stop();
        chk("R6 busy rises after STOP", busy_o, 1);
        rd_addr_i = 11'h123; #1;
        chk("R5 no change during busy", rd_data_o, 8'h00);
        wait_busy(n);
        chk("R6 busy length", n, P);
        peek(11'h123, 8'hA5, "R2 byte stored");

        // R3 wrap inside the page
        send_addr(11'h0FE); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_stop();
        wait_busy(n);
        peek(11'h0FE, 8'h11, "R3 first byte");
        peek(11'h0FF, 8'h22, "R3 second byte");
        peek(11'h0F0, 8'h33, "R3 wrapped byte");
        peek(11'h100, 8'h00, "R3 next page untouched");

        // R4 more than 16 bytes
        send_addr(11'h200);
        for (int i = 0; i < 18; i++) send_byte(8'(8'h40 + i));
        send_stop(); wait_busy(n);
        peek(11'h200, 8'h50, "R4 slot0 overwritten");
        peek(11'h201, 8'h51, "R4 slot1 overwritten");
        peek(11'h202, 8'h42, "R4 slot2 kept");
        peek(11'h20F, 8'h4F, "R4 slot15 kept");

        // R5 only loaded slots updated
        send_addr(11'h300);
        for (int i = 0; i < 16; i++) send_byte(8'hFF);
        send_stop(); wait_busy(n);
        send_addr(11'h305); send_byte(8'h01); send_byte(8'h02); send_stop(); wait_busy(n);
        peek(11'h305, 8'h01, "R5 loaded slot a");
        peek(11'h306, 8'h02, "R5 loaded slot b");
        peek(11'h304, 8'hFF, "R5 unloaded slot below");
        peek(11'h307, 8'hFF, "R5 unloaded slot above");

        // R7 write protect
        wp_i = 1;
        send_addr(11'h455); send_byte(8'h77); send_stop(); wait_busy(n);
        chk("R7 protected busy length", n, P);
        peek(11'h455, 8'h00, "R7 protected unchanged");
        send_addr(11'h055); send_byte(8'h66); send_stop(); wait_busy(n);
        peek(11'h055, 8'h66, "R7 lower half writable");
        wp_i = 0;
        send_addr(11'h455); send_byte(8'h77); send_stop(); wait_busy(n);
        peek(11'h455, 8'h77, "R7 unprotected upper write");

        // R8 STOP with no data
        send_addr(11'h010); send_stop();
        chk("R8 no busy", busy_o, 0);
        repeat (3) @(negedge clk);
        chk("R8 still idle", busy_o, 0);
        peek(11'h010, 8'h00, "R8 array unchanged");

        // R9 traffic during busy ignored
        send_addr(11'h020); send_byte(8'hAA); send_stop();
        send_addr(11'h030); send_byte(8'hBB); send_stop();
        wait_busy(n);
        chk("R9 busy length unaffected", n, P - 6);
        repeat (2) @(negedge clk);
        chk("R9 no second cycle", busy_o, 0);
        peek(11'h020, 8'hAA, "R9 first write done");
        peek(11'h030, 8'h00, "R9 ignored write");

        // R10 same-cycle read
        @(negedge clk); rd_addr_i = 11'h0F0; #1;
        chk("R10 immediate read", rd_data_o, 8'h33);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule